// File: doc/BRIEF.md
# ARINC 429 Word Receiver

This block takes one ARINC 429 channel after the line receiver has turned the differential pair into two logic-level signals: a high-side line and a low-side line. It samples these lines at ten times the bit rate. It filters out short runs and decodes the return-to-zero levels into one bits, zero bits, null and error. It shifts the bits into a 32-bit word. When a word has exactly 32 bits and ends in a long enough null gap, the block hands it to a holding register. The 32nd bit is replaced by a parity-check result.

A host reads the held word through a 16-bit bus in two halves. A ready flag says a word is waiting, and it drops once the upper half has been read. A control input picks the sample rate: every clock of a 1 MHz master clock for 100 kbit/s, or every eighth clock for 12.5 kbit/s. All state belongs to the instance, so two receivers can be placed side by side with separate ready flags.

The word state machine has five states:
- HUNT waits for a null gap after reset or after a fault.
- IDLE waits for the first bit of a word.
- MARK holds the data level of a bit.
- SPACE holds the null level between bits.
- TAIL counts the closing gap after the 32nd bit.

The transitions are:
- HUNT→IDLE when the gap is met.
- IDLE→MARK on a data level.
- MARK→SPACE on null while fewer than 32 bits are held.
- MARK→TAIL on null after bit 32.
- SPACE→MARK on a data level.
- SPACE→IDLE when the gap is met, which abandons a partial word.
- TAIL→IDLE when the gap is met, which delivers the word.
- Any state→HUNT on an error level. MARK, SPACE and TAIL also go to HUNT when a data level arrives where it is not allowed.

Top module: `a429_rx_top`

## Requirements
- R1: Line levels decode as follows:
  - high-side alone is a one bit;
  - low-side alone is a zero bit;
  - neither is null;
  - both is an error, which throws away the partial word so that no word is delivered from it.
- R2: With `lo_speed`=0 the line is sampled on every clock. With `lo_speed`=1 it is sampled once every 8 clocks. A stream paced for the other rate does not produce a word.
- R3: A new line level is accepted only after 3 consecutive equal samples. A 2-sample pulse of any level is ignored.
- R4: The first received bit lands in word bit 0, and later bits fill upward. Bit 31 of the held word is 1 when the 32 received bits have odd parity and 0 otherwise. Bits 30:0 are the received bits.
- R5: A word is delivered only after exactly 32 bits followed by 20 accepted null samples. A partial word followed by that gap is dropped, and the bit count restarts with the next bit.
- R6: A data level that arrives before the 20-sample closing gap ends discards the 32-bit word.
- R7: `word_ready` rises the cycle after a word is delivered. `rd_data` shows bits 15:0 when `rd_half`=0 and bits 31:16 when `rd_half`=1.
- R8: A clock edge with `rd_en`=1 and `rd_half`=1 clears `word_ready`. A lower-half read leaves it set.
- R9: A newly delivered word overwrites an unread one. A delivery in the same cycle as an upper-half read leaves `word_ready` set.
- R10: After reset `word_ready` is 0 and `rd_data` reads 0. The receiver needs a 20-sample null gap before it accepts a first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 1 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_speed | input | 1 | 1 selects the slow sample rate (one sample per 8 clocks) |
| line_hi | input | 1 | High-side logic level from the line receiver |
| line_lo | input | 1 | Low-side logic level from the line receiver |
| rd_en | input | 1 | Read strobe for the holding register |
| rd_half | input | 1 | Half select: 0 lower 16 bits, 1 upper 16 bits |
| rd_data | output | 16 | Selected half of the held word |
| word_ready | output | 1 | A received word is waiting to be read |

## Verification
The bench goes after the boundaries of word framing:
- A 31-bit burst must be dropped rather than padded.
- A closing gap cut short by a new bit must kill the word. A design that counted bits loosely would deliver shifted or truncated words in these cases.
- An error level mid-word must not leak the partial word.
- Two-sample glitches in the null spaces must not turn into extra bits.
- Traffic paced for the wrong rate must not be accepted. A faulty rate divider or run filter would show up here as corrupted or spurious words.

The bench also checks the parity flag with both good and bad parity, overwriting of an unread word, and that only the upper-half read clears the ready flag. A design that clears on either read, or that reports the raw parity bit, fails these checks.

// File: rtl/a429_rx_pkg.sv
`timescale 1ns/1ps
package a429_rx_pkg;

    typedef enum logic [1:0] {
        SYM_NULL = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_ZERO = 2'd2,
        SYM_ERR  = 2'd3
    } sym_t;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_MARK  = 3'd2,
        ST_SPACE = 3'd3,
        ST_TAIL  = 3'd4
    } rx_state_t;

    function automatic sym_t decode_line(input logic hi, input logic lo);
        sym_t s;
        unique case ({hi, lo})
            2'b10:   s = SYM_ONE;
            2'b01:   s = SYM_ZERO;
            2'b11:   s = SYM_ERR;
            default: s = SYM_NULL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/a429_rx_tick.sv
`timescale 1ns/1ps
module a429_rx_tick #(
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_speed,
    output logic samp_tick
);
    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam int DW = $clog2(SLOW_DIV);
            logic [DW-1:0] div_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_cnt <= '0;
                else if (div_cnt == DW'(SLOW_DIV - 1))
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + 1'b1;
            end

            assign samp_tick = lo_speed ? (div_cnt == DW'(SLOW_DIV - 1)) : 1'b1;
        end else begin : g_nodiv
            assign samp_tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/a429_rx_filter.sv
`timescale 1ns/1ps
module a429_rx_filter
    import a429_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_tick,
    input  logic line_hi,
    input  logic line_lo,
    output sym_t lvl,
    output logic acc
);
    localparam int RW = $clog2(MIN_RUN + 1);

    logic [SYNC_STAGES-1:0] hi_sync;
    logic [SYNC_STAGES-1:0] lo_sync;
    sym_t                   raw;
    sym_t                   cand;
    logic [RW-1:0]          run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_sync <= '0;
            lo_sync <= '0;
        end else begin
            for (int s = SYNC_STAGES - 1; s > 0; s--) begin
                hi_sync[s] <= hi_sync[s-1];
                lo_sync[s] <= lo_sync[s-1];
            end
            hi_sync[0] <= line_hi;
            lo_sync[0] <= line_lo;
        end
    end

    assign raw = decode_line(hi_sync[SYNC_STAGES-1], lo_sync[SYNC_STAGES-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= SYM_NULL;
            run  <= RW'(MIN_RUN);
            lvl  <= SYM_NULL;
            acc  <= 1'b0;
        end else begin
            acc <= 1'b0;
            if (samp_tick) begin
                if (raw != cand) begin
                    cand <= raw;
                    run  <= RW'(1);
                end else begin
                    if (run < RW'(MIN_RUN))
                        run <= run + 1'b1;
                    if (run == RW'(MIN_RUN - 1) && cand != lvl) begin
                        lvl <= cand;
                        acc <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/a429_rx_fsm.sv
`timescale 1ns/1ps
module a429_rx_fsm
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int GAP_SAMPLES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_tick,
    input  sym_t                 lvl,
    input  logic                 acc,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] word_raw,
    output logic                 par_ok
);
    localparam int CW = $clog2(WORD_BITS + 1);
    localparam int NW = $clog2(GAP_SAMPLES + 1);

    rx_state_t      state, nxt;
    logic [CW-1:0]  bit_cnt;
    logic [NW-1:0]  null_cnt;
    logic           is_data;
    logic           gap_met;
    logic           take_bit;
    logic           done_nxt;

    assign is_data  = (lvl == SYM_ONE) || (lvl == SYM_ZERO);
    assign gap_met  = (lvl == SYM_NULL) && (null_cnt == NW'(GAP_SAMPLES));
    assign take_bit = acc && is_data && (state == ST_IDLE || state == ST_SPACE);
    assign done_nxt = (state == ST_TAIL) && !acc && gap_met;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (gap_met)
                    nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (acc && is_data)
                    nxt = ST_MARK;
                else if (acc && lvl == SYM_ERR)
                    nxt = ST_HUNT;
            end
            ST_MARK: begin
                if (acc) begin
                    if (lvl == SYM_NULL)
                        nxt = (bit_cnt == CW'(WORD_BITS)) ? ST_TAIL : ST_SPACE;
                    else
                        nxt = ST_HUNT;
                end
            end
            ST_SPACE: begin
                if (acc)
                    nxt = is_data ? ST_MARK : ST_HUNT;
                else if (gap_met)
                    nxt = ST_IDLE;
            end
            ST_TAIL: begin
                if (acc)
                    nxt = ST_HUNT;
                else if (gap_met)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            null_cnt <= '0;
        else if (acc)
            null_cnt <= '0;
        else if (samp_tick && lvl == SYM_NULL && null_cnt < NW'(GAP_SAMPLES))
            null_cnt <= null_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_raw <= '0;
            bit_cnt  <= '0;
            par_ok   <= 1'b0;
        end else if (take_bit) begin
            word_raw <= {(lvl == SYM_ONE), word_raw[WORD_BITS-1:1]};
            if (state == ST_IDLE) begin
                bit_cnt <= CW'(1);
                par_ok  <= (lvl == SYM_ONE);
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
                par_ok  <= par_ok ^ (lvl == SYM_ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            word_done <= 1'b0;
        else
            word_done <= done_nxt;
    end
endmodule

// File: rtl/a429_rx_hold.sv
`timescale 1ns/1ps
module a429_rx_hold #(
    parameter int WORD_BITS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_done,
    input  logic [WORD_BITS-1:0]   word_raw,
    input  logic                   par_ok,
    input  logic                   rd_en,
    input  logic                   rd_half,
    output logic [WORD_BITS/2-1:0] rd_data,
    output logic                   word_ready,
    output logic [WORD_BITS-1:0]   hold_word
);
    localparam int HW = WORD_BITS / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word  <= '0;
            word_ready <= 1'b0;
        end else if (word_done) begin
            hold_word  <= {par_ok, word_raw[WORD_BITS-2:0]};
            word_ready <= 1'b1;
        end else if (rd_en && rd_half) begin
            word_ready <= 1'b0;
        end
    end

    assign rd_data = rd_half ? hold_word[WORD_BITS-1:HW] : hold_word[HW-1:0];
endmodule

// File: rtl/a429_rx_top.sv
`timescale 1ns/1ps
module a429_rx_top
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int SLOW_DIV    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 3,
    parameter int GAP_SAMPLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_speed,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        rd_en,
    input  logic        rd_half,
    output logic [15:0] rd_data,
    output logic        word_ready
);
    logic                 samp_tick;
    sym_t                 lvl;
    logic                 acc;
    logic                 word_done;
    logic [WORD_BITS-1:0] word_raw;
    logic                 par_ok;
    logic [WORD_BITS-1:0] hold_word;

    a429_rx_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_speed  (lo_speed),
        .samp_tick (samp_tick)
    );

    a429_rx_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_RUN(MIN_RUN)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_tick),
        .line_hi   (line_hi),
        .line_lo   (line_lo),
        .lvl       (lvl),
        .acc       (acc)
    );

    a429_rx_fsm #(.WORD_BITS(WORD_BITS), .GAP_SAMPLES(GAP_SAMPLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_tick),
        .lvl       (lvl),
        .acc       (acc),
        .word_done (word_done),
        .word_raw  (word_raw),
        .par_ok    (par_ok)
    );

    a429_rx_hold #(.WORD_BITS(WORD_BITS)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .word_raw   (word_raw),
        .par_ok     (par_ok),
        .rd_en      (rd_en),
        .rd_half    (rd_half),
        .rd_data    (rd_data),
        .word_ready (word_ready),
        .hold_word  (hold_word)
    );
endmodule

// File: rtl/a429_rx_chk.sv
`timescale 1ns/1ps
module a429_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lo_speed,
    input logic        samp_tick,
    input logic [1:0]  lvl,
    input logic        word_done,
    input logic [31:0] word_raw,
    input logic [31:0] hold_word,
    input logic        rd_en,
    input logic        rd_half,
    input logic        word_ready
);
    // R4: held word carries payload bits and the parity verdict
    a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (hold_word[31] == ^$past(word_raw)) &&
                      (hold_word[30:0] == $past(word_raw[30:0])));

    // R7: ready follows a delivery
    a_r7_ready_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> word_ready);

    // R7: ready rises only because of a delivery
    a_r7_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_ready) |-> $past(word_done));

    // R8: upper-half read clears ready unless a word lands at once
    a_r8_upper_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_half && !word_done) |=> !word_ready);

    // R8: ready holds without an upper-half read
    a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !(rd_en && rd_half)) |=> word_ready);

    // R2: fast rate samples every clock
    a_r2_fast_every: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_speed |-> samp_tick);

    // R2: slow rate never samples on two adjacent clocks
    a_r2_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_speed && $past(lo_speed) && samp_tick) |-> !$past(samp_tick));

    // R1: an error level never coincides with a delivery
    a_r1_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'd3) |-> !word_done);
endmodule

bind a429_rx_top a429_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_speed   (lo_speed),
    .samp_tick  (samp_tick),
    .lvl        (lvl),
    .word_done  (word_done),
    .word_raw   (word_raw),
    .hold_word  (hold_word),
    .rd_en      (rd_en),
    .rd_half    (rd_half),
    .word_ready (word_ready)
);

// File: tb/sim_a429_rx_top.sv
`timescale 1ns/1ps
module sim_a429_rx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_speed = 1'b0;
    logic        line_hi = 1'b0;
    logic        line_lo = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_half = 1'b0;
    logic [15:0] rd_data;
    logic        word_ready;

    int errors = 0;
    int checks = 0;
    int spc = 1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    a429_rx_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_speed   (lo_speed),
        .line_hi    (line_hi),
        .line_lo    (line_lo),
        .rd_en      (rd_en),
        .rd_half    (rd_half),
        .rd_data    (rd_data),
        .word_ready (word_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] with_par(input logic [30:0] pay, input bit good);
        return {(good ? ~^pay : ^pay), pay};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] w);
        return {^w, w[30:0]};
    endfunction

    task automatic put(input logic h, input logic l, input int n);
        line_hi = h;
        line_lo = l;
        repeat (n * spc) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, input bit glitch);
        for (int i = 0; i < n; i++) begin
            put(w[i], !w[i], 5);
            if (glitch) begin
                put(1'b0, 1'b0, 2);
                put(i[0], !i[0], 2);
                put(1'b0, 1'b0, 3);
            end else begin
                put(1'b0, 1'b0, 5);
            end
        end
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        rd_en = 1'b0;
        rd_half = 1'b0;
        #1 chk(req, {16'h0, rd_data}, {16'h0, exp[15:0]});
        rd_half = 1'b1;
        #1 chk(req, {16'h0, rd_data}, {16'h0, exp[31:16]});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rd_half = 1'b0;
        #1 chk("R8 ready cleared by upper read", {31'h0, word_ready}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, w2;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 ready after reset", {31'h0, word_ready}, 32'h0);
        chk("R10 data after reset", {16'h0, rd_data}, 32'h0);
        put(1'b0, 1'b0, 40);

        // R1/R4 directed word with good parity
        w = with_par(31'h2A5C_3F01, 1'b1);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        chk("R5 ready after word", {31'h0, word_ready}, 32'h1);
        read_word("R4 good parity word", exp_word(w));

        // R4 bad parity
        w = with_par(31'h0000_0081, 1'b0);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        read_word("R4 bad parity flag", exp_word(w));

        // R4/R7 random words
        for (int k = 0; k < 6; k++) begin
            w = with_par(31'($urandom), bit'($urandom % 2));
            send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
            chk("R7 ready random", {31'h0, word_ready}, 32'h1);
            read_word("R4 random word", exp_word(w));
        end

        // R8 lower read keeps ready
        w = with_par(31'h1234_5678, 1'b1);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        rd_en = 1'b1; rd_half = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        #1 chk("R8 lower read keeps ready", {31'h0, word_ready}, 32'h1);
        read_word("R8 word after lower read", exp_word(w));

        // R9 overwrite of unread word
        w = with_par(31'h7FFF_0000, 1'b1);
        w2 = with_par(31'h0F0F_F0F0, 1'b0);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        send_bits(w2, 32, 1'b0); put(1'b0, 1'b0, 40);
        read_word("R9 newest word kept", exp_word(w2));

        // R5 31 bits then gap: nothing, then a full word decodes cleanly
        send_bits(32'hFFFF_FFFF, 31, 1'b0); put(1'b0, 1'b0, 40);
        chk("R5 31 bits dropped", {31'h0, word_ready}, 32'h0);
        w = with_par(31'h5555_AAAA, 1'b1);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        read_word("R5 count restarts", exp_word(w));

        // R1 error level mid-word discards
        w = with_par(31'h3333_3333, 1'b1);
        send_bits(w, 10, 1'b0);
        put(1'b1, 1'b1, 5);
        put(1'b0, 1'b0, 5);
        send_bits(w, 22, 1'b0); put(1'b0, 1'b0, 40);
        chk("R1 error discards word", {31'h0, word_ready}, 32'h0);

        // R6 short closing gap
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 10);
        send_bits(32'h1, 1, 1'b0); put(1'b0, 1'b0, 40);
        chk("R6 short gap discards", {31'h0, word_ready}, 32'h0);

        // R3 two-sample glitches in null spaces
        w = with_par(31'h6C3A_91E5, 1'b1);
        send_bits(w, 32, 1'b1); put(1'b0, 1'b0, 40);
        chk("R3 ready with glitches", {31'h0, word_ready}, 32'h1);
        read_word("R3 glitches ignored", exp_word(w));

        // R2 slow pacing in fast mode is rejected
        spc = 8;
        w = with_par(31'h0BAD_CAFE, 1'b1);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        chk("R2 wrong rate rejected", {31'h0, word_ready}, 32'h0);

        // R2 slow mode accepts slow pacing
        lo_speed = 1'b1;
        put(1'b0, 1'b0, 40);
        send_bits(w, 32, 1'b0); put(1'b0, 1'b0, 40);
        chk("R2 slow word ready", {31'h0, word_ready}, 32'h1);
        read_word("R2 slow word", exp_word(w));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule